// File: doc/BRIEF.md
# System Bus Address Decoder

This block sits between a 16-bit main processor with a 24-bit byte address and the devices hanging off its bus. Each access is given by a strobe, a write flag, a size flag (byte or word), an address and write data. The block classifies the address into one of eight device classes and raises the matching select. It presents each device with an address and write data already arranged for that device. It also folds the data returned by the selected device back into the 16-bit read value the processor expects.

Besides the plain decode, the block does four things. It keeps one register that chooses whether the low 4 MiB read the cartridge or a 2 KiB boot image. It opens the coprocessor window only while the bus is granted. It copies byte writes onto both lanes of 16-bit devices. It moves the single I/O byte onto the high or low lane depending on which mirror of the I/O space was used. Decode and steering are combinational. The only state is the overlay bit.

Top module: `sysbus_decoder`

## Requirements
- R1: `sel` has at most one bit set, and is all zero while `acc_valid` is low. Bit positions are 0 cartridge, 1 boot image, 2 coprocessor, 3 I/O, 4 cartridge I/O, 5 video, 6 sound, 7 work RAM.
- R2: Any write in 0x000000–0x3FFFFF selects the cartridge. Reads there select the cartridge when the overlay bit is 1 and the boot image when it is 0. The boot image gets `bus_addr` = {13'b0, addr[10:1], 1'b0}. The cartridge gets {addr[23:1], 1'b0}.
- R3: After reset the overlay bit is 0. A write anywhere in 0xA14100–0xA141FF loads it from bit 0 of the steered I/O byte (R9). A word write therefore uses data bit 8. The new value governs accesses from the next clock edge on.
- R4: For a byte read from the cartridge, boot image, video port or RAM, `acc_rdata` is {8'h00, b}. Here b is `bus_rdata[15:8]` at an even address and `bus_rdata[7:0]` at an odd one. A word read returns `bus_rdata` unchanged.
- R5: `bus_be` is 2'b11 for a word and 2'b10 (high lane) or 2'b01 (low lane) for an even or odd byte. For a byte write to the cartridge, video port or RAM, `bus_wdata` carries the data byte on both lanes.
- R6: 0xA00000–0xA0FFFF selects the coprocessor only while `cop_granted` is 1, with `bus_addr` = the full address. Reads return {8'h00, `bus_rdata[7:0]`}. While it is not granted, nothing is selected and reads return zero.
- R7: 0xE00000–0xFFFFFF selects work RAM with `bus_addr` = {8'b0, addr[15:1], 1'b0}, so all 32 copies of the 64 KiB map to the same words.
- R8: For reads, 0xC00000–0xDFFFFF selects video. For writes, only 0xC00000–0xC0000F selects video, and only 0xC00010–0xC00017 selects sound. `bus_wdata` to the sound port is `acc_wdata` as given. Sound never appears on a read.
- R9: I/O is selected by 0xA10000–0xA11FFF for any access and by 0xA14000–0xA141FF for writes only. The high-lane mirrors are 0xA11000–0xA11FFF and 0xA14100–0xA141FF; they get `bus_addr` = addr with bits 7:0 cleared. The low-lane mirrors get addr with bits 15:8 and bit 0 cleared. The device byte is `bus_rdata[7:0]` and the written byte goes out on `bus_wdata[7:0]` with the upper lane zero. A word access takes or returns that byte on the high lane in a high-lane mirror and on the low lane otherwise. A byte access always uses data bits 7:0.
- R10: 0xA13000–0xA130FF selects cartridge I/O with the full address, and data passes through unchanged in both directions.
- R11: Any other address selects nothing. A read from it returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overlay bit |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 16-bit access, 0 = byte |
| acc_addr | input | 24 | Byte address from the processor |
| acc_wdata | input | 16 | Write data from the processor |
| acc_rdata | output | 16 | Read data returned to the processor |
| cop_granted | input | 1 | Coprocessor bus grant |
| sel | output | 8 | One-hot device select (order in R1) |
| bus_addr | output | 24 | Address presented to the selected device |
| bus_be | output | 2 | Lane enables, bit 1 = high lane |
| bus_wdata | output | 16 | Steered write data |
| bus_rdata | input | 16 | Data returned by the selected device |

## Verification
Almost every fault here is combinational, so a wrong window edge or lane choice shows up on `sel`, `bus_addr` or `acc_rdata` in the same cycle as the access. The bench therefore walks each window's first and last byte, and the byte just outside it, under every mix of read/write, size and grant. The one stored bit fails differently. A bad overlay update stays hidden until the next read of the low 4 MiB, one edge later at the earliest. For that reason the sweep runs once with the overlay cleared and once with it set, and directed writes probe both data bit positions that can load it.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int LANES   = DATA_W / BYTE_W;
    localparam int BOOT_AW = 11;
    localparam int RAM_AW  = 16;
    localparam int NDEV    = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // select bit positions follow the enum values
    typedef enum logic [2:0] {
        D_CART   = 3'd0,
        D_BOOT   = 3'd1,
        D_COP    = 3'd2,
        D_IO     = 3'd3,
        D_CARTIO = 3'd4,
        D_VIDEO  = 3'd5,
        D_SOUND  = 3'd6,
        D_RAM    = 3'd7
    } dev_e;

    typedef struct packed {
        logic hit;
        dev_e dev;
        logic io_hi;   // I/O mirror that uses the high lane
    } dec_t;

    localparam addr_t ROM_HI   = 24'h3F_FFFF;
    localparam addr_t COP_LO   = 24'hA0_0000;
    localparam addr_t COP_HI   = 24'hA0_FFFF;
    localparam addr_t IOL_LO   = 24'hA1_0000;
    localparam addr_t IOL_HI   = 24'hA1_0FFF;
    localparam addr_t IOH_LO   = 24'hA1_1000;
    localparam addr_t IOH_HI   = 24'hA1_1FFF;
    localparam addr_t CIO_LO   = 24'hA1_3000;
    localparam addr_t CIO_HI   = 24'hA1_30FF;
    localparam addr_t IOWL_LO  = 24'hA1_4000;
    localparam addr_t IOWL_HI  = 24'hA1_40FF;
    localparam addr_t OVL_LO   = 24'hA1_4100;
    localparam addr_t OVL_HI   = 24'hA1_41FF;
    localparam addr_t VID_LO   = 24'hC0_0000;
    localparam addr_t VID_HI   = 24'hDF_FFFF;
    localparam addr_t VIDW_HI  = 24'hC0_000F;
    localparam addr_t SND_LO   = 24'hC0_0010;
    localparam addr_t SND_HI   = 24'hC0_0017;
    localparam addr_t RAM_LO   = 24'hE0_0000;

    function automatic logic in_win(addr_t a, addr_t lo, addr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic dec_t classify(addr_t a, logic wr, logic rom_on, logic granted);
        dec_t d;
        d = '{hit: 1'b0, dev: D_CART, io_hi: 1'b0};
        if (a <= ROM_HI) begin
            d.hit = 1'b1;
            d.dev = (wr || rom_on) ? D_CART : D_BOOT;
        end else if (in_win(a, COP_LO, COP_HI)) begin
            d.hit = granted;
            d.dev = D_COP;
        end else if (in_win(a, IOL_LO, IOL_HI)) begin
            d.hit = 1'b1;
            d.dev = D_IO;
        end else if (in_win(a, IOH_LO, IOH_HI)) begin
            d.hit   = 1'b1;
            d.dev   = D_IO;
            d.io_hi = 1'b1;
        end else if (in_win(a, CIO_LO, CIO_HI)) begin
            d.hit = 1'b1;
            d.dev = D_CARTIO;
        end else if (in_win(a, IOWL_LO, IOWL_HI)) begin
            d.hit = wr;
            d.dev = D_IO;
        end else if (in_win(a, OVL_LO, OVL_HI)) begin
            d.hit   = wr;
            d.dev   = D_IO;
            d.io_hi = 1'b1;
        end else if (in_win(a, VID_LO, VID_HI)) begin
            if (!wr || a <= VIDW_HI) begin
                d.hit = 1'b1;
                d.dev = D_VIDEO;
            end else if (in_win(a, SND_LO, SND_HI)) begin
                d.hit = 1'b1;
                d.dev = D_SOUND;
            end
        end else if (a >= RAM_LO) begin
            d.hit = 1'b1;
            d.dev = D_RAM;
        end
        return d;
    endfunction
endpackage

// File: rtl/sysbus_decode.sv
module sysbus_decode
    import sysbus_pkg::*;
(
    input  logic            valid,
    input  logic            write,
    input  addr_t           addr,
    input  logic            rom_on,
    input  logic            granted,
    output dec_t            dec,
    output logic [NDEV-1:0] sel
);
    always_comb dec = classify(addr, write, rom_on, granted);

    for (genvar i = 0; i < NDEV; i++) begin : g_sel
        assign sel[i] = valid && dec.hit && (dec.dev == dev_e'(i));
    end
endmodule

// File: rtl/sysbus_steer.sv
module sysbus_steer
    import sysbus_pkg::*;
(
    input  logic             valid,
    input  dec_t             dec,
    input  addr_t            addr,
    input  logic             word,
    input  word_t            wdata,
    input  word_t            dev_rdata,
    output addr_t            bus_addr,
    output logic [LANES-1:0] bus_be,
    output word_t            bus_wdata,
    output word_t            rdata,
    output byte_t            io_byte
);
    localparam byte_t ZB = '0;

    byte_t lane_rd;
    word_t wide_rd;
    word_t repl_wd;

    always_comb begin
        io_byte = (word && dec.io_hi) ? wdata[DATA_W-1 -: BYTE_W] : wdata[BYTE_W-1:0];
        bus_be  = word ? {LANES{1'b1}} : (addr[0] ? LANES'(1) : LANES'(2));
        lane_rd = addr[0] ? dev_rdata[BYTE_W-1:0] : dev_rdata[DATA_W-1 -: BYTE_W];
        wide_rd = word ? dev_rdata : {ZB, lane_rd};
        repl_wd = word ? wdata : {LANES{wdata[BYTE_W-1:0]}};

        bus_addr  = addr;
        bus_wdata = wdata;
        rdata     = '0;
        unique case (dec.dev)
            D_CART, D_VIDEO: begin
                bus_addr  = {addr[ADDR_W-1:1], 1'b0};
                bus_wdata = repl_wd;
                rdata     = wide_rd;
            end
            D_BOOT: begin
                bus_addr = ADDR_W'({addr[BOOT_AW-1:1], 1'b0});
                rdata    = wide_rd;
            end
            D_RAM: begin
                bus_addr  = ADDR_W'({addr[RAM_AW-1:1], 1'b0});
                bus_wdata = repl_wd;
                rdata     = wide_rd;
            end
            D_IO: begin
                bus_addr  = dec.io_hi ? (addr & ~ADDR_W'(24'h0000FF))
                                      : (addr & ~ADDR_W'(24'h00FF01));
                bus_wdata = {ZB, io_byte};
                rdata     = (word && dec.io_hi) ? {dev_rdata[BYTE_W-1:0], ZB}
                                                : {ZB, dev_rdata[BYTE_W-1:0]};
            end
            D_COP:    rdata = {ZB, dev_rdata[BYTE_W-1:0]};
            D_CARTIO: rdata = dev_rdata;
            D_SOUND:  rdata = '0;
            default:  rdata = '0;
        endcase
        if (!(valid && dec.hit)) rdata = '0;
    end
endmodule

// File: rtl/sysbus_overlay.sv
module sysbus_overlay (
    input  logic clk,
    input  logic rst,
    input  logic ctl_we,
    input  logic ctl_bit,
    output logic rom_on
);
    always_ff @(posedge clk) begin
        if (rst)         rom_on <= 1'b0;
        else if (ctl_we) rom_on <= ctl_bit;
    end
endmodule

// File: rtl/sysbus_decoder.sv
module sysbus_decoder
    import sysbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic                 acc_word,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [DATA_W-1:0]    acc_wdata,
    output logic [DATA_W-1:0]    acc_rdata,
    input  logic                 cop_granted,
    output logic [NDEV-1:0]      sel,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [LANES-1:0]     bus_be,
    output logic [DATA_W-1:0]    bus_wdata,
    input  logic [DATA_W-1:0]    bus_rdata
);
    dec_t  dec;
    logic  rom_on;
    byte_t io_byte;
    logic  ctl_we;

    assign ctl_we = acc_valid && acc_write && in_win(acc_addr, OVL_LO, OVL_HI);

    sysbus_overlay u_ovl (
        .clk     (clk),
        .rst     (rst),
        .ctl_we  (ctl_we),
        .ctl_bit (io_byte[0]),
        .rom_on  (rom_on)
    );

    sysbus_decode u_dec (
        .valid   (acc_valid),
        .write   (acc_write),
        .addr    (acc_addr),
        .rom_on  (rom_on),
        .granted (cop_granted),
        .dec     (dec),
        .sel     (sel)
    );

    sysbus_steer u_steer (
        .valid     (acc_valid),
        .dec       (dec),
        .addr      (acc_addr),
        .word      (acc_word),
        .wdata     (acc_wdata),
        .dev_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .rdata     (acc_rdata),
        .io_byte   (io_byte)
    );
endmodule

// File: rtl/sysbus_checker.sv
module sysbus_checker (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        acc_word,
    input logic [23:0] acc_addr,
    input logic [15:0] acc_wdata,
    input logic [15:0] acc_rdata,
    input logic        cop_granted,
    input logic [7:0]  sel,
    input logic [23:0] bus_addr,
    input logic [15:0] bus_wdata
);
    logic ovl_wr;
    logic ovl_val;
    logic rom_rd;
    assign ovl_wr  = acc_valid && acc_write && (acc_addr[23:8] == 16'hA141);
    assign ovl_val = acc_word ? acc_wdata[8] : acc_wdata[0];
    assign rom_rd  = acc_valid && !acc_write && (acc_addr[23:22] == 2'b00);

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (sel == 8'h00));
    assert_overlay_next_R3: assert property (@(posedge clk) disable iff (rst)
        ovl_wr |=> (!rom_rd || (sel[0] == $past(ovl_val))));
    assert_byte_repl_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_write && !acc_word && (sel[0] || sel[5] || sel[7]))
        |-> (bus_wdata[15:8] == bus_wdata[7:0]));
    assert_cop_grant_R6: assert property (@(posedge clk) disable iff (rst)
        sel[2] |-> cop_granted);
    assert_ram_mirror_R7: assert property (@(posedge clk) disable iff (rst)
        sel[7] |-> (bus_addr[15:1] == acc_addr[15:1] && bus_addr[23:16] == 8'h00));
    assert_sound_write_R8: assert property (@(posedge clk) disable iff (rst)
        sel[6] |-> acc_write);
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && sel == 8'h00) |-> (acc_rdata == 16'h0000));
endmodule

bind sysbus_decoder sysbus_checker u_chk (.*);

// File: tb/sim_sysbus_decoder.sv
module sim_sysbus_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_word = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        cop_granted = 1'b0;
    logic [7:0]  sel;
    logic [23:0] bus_addr;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit model_rom = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // device model: data derived from the address it is given
    assign bus_rdata = bus_addr[15:0] ^ 16'h5A3C;

    sysbus_decoder u0 (.*);

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h (addr=%h wr=%0d word=%0d)",
                     tag, what, act, exp, acc_addr, acc_write, acc_word);
        end
    endtask

    function automatic int exp_dev(logic [23:0] a, bit wr, bit rom, bit g);
        if (a <= 24'h3FFFFF) return (wr || rom) ? 0 : 1;
        if (a >= 24'hA00000 && a <= 24'hA0FFFF) return g ? 2 : -1;
        if (a >= 24'hA10000 && a <= 24'hA11FFF) return 3;
        if (a >= 24'hA13000 && a <= 24'hA130FF) return 4;
        if (a >= 24'hA14000 && a <= 24'hA141FF) return wr ? 3 : -1;
        if (a >= 24'hC00000 && a <= 24'hDFFFFF) begin
            if (!wr || a <= 24'hC0000F) return 5;
            if (a >= 24'hC00010 && a <= 24'hC00017) return 6;
            return -1;
        end
        if (a >= 24'hE00000) return 7;
        return -1;
    endfunction

    function automatic string tag_of(int d);
        case (d)
            0, 1:    return "R2";
            2:       return "R6";
            3:       return "R9";
            4:       return "R10";
            5, 6:    return "R8";
            7:       return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic access(logic [23:0] a, bit wr, bit word, logic [15:0] wd, bit g);
        int d;
        bit hi;
        logic [7:0]  exp_sel;
        logic [23:0] ea;
        logic [15:0] dv, er, ew;
        string t;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_word = word;
        acc_addr = a; acc_wdata = wd; cop_granted = g;
        #5;
        d = exp_dev(a, wr, model_rom, g);
        t = tag_of(d);
        exp_sel = (d < 0) ? 8'h00 : 8'(1 << d);
        chk(sel == exp_sel, t, "sel", 32'(sel), 32'(exp_sel));
        chk($countones(sel) <= 1, "R1", "one-hot", 32'(sel), 32'(exp_sel));
        hi = (a[23:12] == 12'hA11) || (a[23:8] == 16'hA141);
        if (d >= 0) begin
            case (d)
                0, 5:    ea = {a[23:1], 1'b0};
                1:       ea = {13'd0, a[10:1], 1'b0};
                7:       ea = {8'd0, a[15:1], 1'b0};
                3:       ea = hi ? (a & ~24'h0000FF) : (a & ~24'h00FF01);
                default: ea = a;
            endcase
            chk(bus_addr == ea, t, "bus_addr", 32'(bus_addr), 32'(ea));
            chk(bus_be == (word ? 2'b11 : (a[0] ? 2'b01 : 2'b10)), "R5", "bus_be",
                32'(bus_be), 32'(word ? 2'b11 : (a[0] ? 2'b01 : 2'b10)));
            dv = ea[15:0] ^ 16'h5A3C;
            if (!wr) begin
                case (d)
                    0, 1, 5, 7: er = word ? dv : {8'h00, (a[0] ? dv[7:0] : dv[15:8])};
                    3:          er = (word && hi) ? {dv[7:0], 8'h00} : {8'h00, dv[7:0]};
                    2:          er = {8'h00, dv[7:0]};
                    default:    er = dv;
                endcase
                chk(acc_rdata == er, word ? t : "R4", "rdata", 32'(acc_rdata), 32'(er));
            end else begin
                case (d)
                    0, 5, 7: ew = word ? wd : {wd[7:0], wd[7:0]};
                    3:       ew = {8'h00, ((word && hi) ? wd[15:8] : wd[7:0])};
                    default: ew = wd;
                endcase
                chk(bus_wdata == ew, word ? t : "R5", "bus_wdata", 32'(bus_wdata), 32'(ew));
            end
        end else if (!wr) begin
            chk(acc_rdata == 16'h0000, "R11", "rdata", 32'(acc_rdata), 32'h0);
        end
        @(posedge clk);
        if (wr && a[23:8] == 16'hA141) model_rom = word ? wd[8] : wd[0];
    endtask

    task automatic idle_check(logic [23:0] a);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_word = 1'b1; acc_addr = a;
        #5;
        chk(sel == 8'h00, "R1", "idle sel", 32'(sel), 32'h0);
        chk(acc_rdata == 16'h0000, "R1", "idle rdata", 32'(acc_rdata), 32'h0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    localparam int NA = 36;
    logic [23:0] addrs [NA] = '{
        24'h000000, 24'h000001, 24'h0007FF, 24'h123457, 24'h3FFFFF, 24'h400000,
        24'h9FFFFF, 24'hA00000, 24'hA0FFFF, 24'hA10000, 24'hA10003, 24'hA10FFF,
        24'hA11000, 24'hA11101, 24'hA11FFF, 24'hA12000, 24'hA13000, 24'hA130FF,
        24'hA13100, 24'hA14000, 24'hA14001, 24'hA140FF, 24'hA14100, 24'hA141FF,
        24'hA14200, 24'hBFFFFF, 24'hC00000, 24'hC0000F, 24'hC00010, 24'hC00017,
        24'hC00018, 24'hDFFFFF, 24'hE00000, 24'hE12345, 24'hFFFFFF, 24'hF0FFFE
    };

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state: idle, and a ROM read reaches the boot image (R3)
        idle_check(24'h000100);
        access(24'h000100, 1'b0, 1'b1, 16'h0000, 1'b0);
        chk(model_rom == 1'b0, "R3", "reset overlay", 32'(model_rom), 32'h0);

        for (int pass = 0; pass < 2; pass++) begin
            access(24'hA14100, 1'b1, 1'b1, pass[0] ? 16'h0100 : 16'h0000, 1'b0);
            for (int i = 0; i < NA; i++)
                for (int wr = 0; wr < 2; wr++)
                    for (int word = 0; word < 2; word++)
                        for (int g = 0; g < 2; g++)
                            access(addrs[i], wr[0], word[0],
                                   {8'(i * 29 + pass * 7 + wr), 8'(i * 53 + word * 5 + g)},
                                   g[0]);
        end

        // R3 directed: byte write uses bit 0, word write uses bit 8
        access(24'hA141FF, 1'b1, 1'b0, 16'hFE01, 1'b0);
        access(24'h000002, 1'b0, 1'b1, 16'h0000, 1'b0);
        chk(sel == 8'h01, "R3", "overlay set by byte", 32'(sel), 32'h1);
        access(24'hA14100, 1'b1, 1'b1, 16'h00FF, 1'b0);
        access(24'h000002, 1'b0, 1'b1, 16'h0000, 1'b0);
        chk(sel == 8'h02, "R3", "overlay cleared by word", 32'(sel), 32'h2);
        // a read of the control window leaves the overlay untouched
        access(24'hA14100, 1'b0, 1'b1, 16'h0000, 1'b0);
        access(24'h000003, 1'b0, 1'b0, 16'h0000, 1'b0);
        chk(sel == 8'h02, "R3", "overlay after read", 32'(sel), 32'h2);

        idle_check(24'hE00000);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule